// File: doc/BRIEF.md
# Integer ALU with Flag Generation

This block is the integer execution stage of a small RISC core. It takes the two register operands already read by the core, plus the raw short (5-bit) and long (16-bit) immediate fields of the instruction, and an operation code from the decoder. From these it computes a 32-bit result and a write-enable for the destination register. It also produces, for each of the condition flags, a new value and an update mask. The core merges the new values into its status word only where the mask bit is set.

Seven operations are supported:

- addition in three forms: register + register, register + short immediate, and register + long immediate;
- AND in two forms: register with register, and register with long immediate;
- compare in two forms: register against register, and register against short immediate.

The operations differ in how the immediate is extended and in which flags they touch. The long immediate is sign-extended for addition but zero-extended for AND. Compare computes a difference only to set flags and never writes a register.

Inputs are sampled on a rising clock edge and all outputs are registered, so every operation takes exactly one clock. A synchronous active-high reset clears all outputs.

Top module: `alu_flag_unit`

## Requirements
- R1: During and right after reset, `result`, `wr_en`, `flag_val` and `flag_mask` are all zero. Outputs reflect the inputs sampled at the previous rising edge (one-cycle latency).
- R2: Operation codes are as follows: 0 = add `rs2+rs1`; 1 = add `rs2+sext(imm_s)`; 2 = add `rs1+sext(imm_l)`; 3 = AND `rs2&rs1`; 4 = AND `rs1&zext(imm_l)`; 5 = compare `rs2-rs1`; 6 = compare `rs2-sext(imm_s)`; 7 = no operation. `result` carries the sum, AND or difference.
- R3: Flag bit positions in `flag_val` and `flag_mask` are: zero = bit 0, sign = bit 1, overflow = bit 2, carry = bit 3, saturation = bit 4. All add and compare operations set mask bits 3..0.
- R4: For addition, carry is the carry-out of bit 31. For compare, carry is set when the subtraction borrows (`rs2` is unsigned-less-than the subtrahend).
- R5: Overflow is set on signed two's-complement overflow of the add or subtract.
- R6: Sign equals bit 31 of `result` and zero is set when `result` is all zeros, for every operation that updates them.
- R7: Register AND (op 3) sets mask bits zero, sign and overflow, with overflow value 0. Carry is left unchanged (mask bit 3 clear).
- R8: Immediate AND (op 4) zero-extends `imm_l`. It sets mask bits zero, sign and overflow, with sign and overflow values 0, and leaves carry unchanged.
- R9: Compare (ops 5, 6) never asserts `wr_en`. Add and AND operations always assert it.
- R10: Saturation mask bit 4 is always 0. Any `flag_val` bit whose mask bit is clear reads 0.
- R11: Op 7 produces `result` 0, `wr_en` 0 and an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code (see R2) |
| rs1 | input | 32 | First register operand |
| rs2 | input | 32 | Second register operand |
| imm_s | input | 5 | Short immediate field |
| imm_l | input | 16 | Long immediate field |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Destination register write-enable |
| flag_val | output | 5 | New flag values (bit map in R3) |
| flag_mask | output | 5 | Flag update mask (bit map in R3) |

## Verification
Carry and overflow can both be raised by a single addition. For example, `0x80000000 + 0x80000000` wraps to zero and so raises carry, overflow and zero together. The bench drives that case and its subtract counterpart, and compares every flag bit against a 33-bit reference model. Compare of equal operands exercises zero together with no borrow. An immediate AND whose masked result has bit 31 clear on a negative register tests that forced-zero sign does not leak from the operand.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD_RR  = 3'd0,
    OP_ADD_IS  = 3'd1,
    OP_ADD_IL  = 3'd2,
    OP_AND_RR  = 3'd3,
    OP_AND_IL  = 3'd4,
    OP_CMP_RR  = 3'd5,
    OP_CMP_IS  = 3'd6,
    OP_NONE    = 3'd7
  } alu_op_e;

  localparam int FLAG_W  = 5;
  localparam int FZ_BIT  = 0;
  localparam int FS_BIT  = 1;
  localparam int FOV_BIT = 2;
  localparam int FCY_BIT = 3;
  localparam int FSAT_BIT = 4;

endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_S_W = 5,
  parameter int IMM_L_W = 16
) (
  input  alu_op_e              op,
  input  logic [DATA_W-1:0]    rs1,
  input  logic [DATA_W-1:0]    rs2,
  input  logic [IMM_S_W-1:0]   imm_s,
  input  logic [IMM_L_W-1:0]   imm_l,
  output logic [DATA_W-1:0]    src_a,
  output logic [DATA_W-1:0]    src_b,
  output logic                 do_sub
);

  localparam int PAD_S = DATA_W - IMM_S_W;
  localparam int PAD_L = DATA_W - IMM_L_W;

  logic [DATA_W-1:0] sx_short;
  logic [DATA_W-1:0] sx_long;
  logic [DATA_W-1:0] zx_long;

  generate
    if (PAD_S > 0) begin : g_ext_s
      assign sx_short = {{PAD_S{imm_s[IMM_S_W-1]}}, imm_s};
    end else begin : g_trunc_s
      assign sx_short = imm_s[DATA_W-1:0];
    end
    if (PAD_L > 0) begin : g_ext_l
      assign sx_long = {{PAD_L{imm_l[IMM_L_W-1]}}, imm_l};
      assign zx_long = {{PAD_L{1'b0}}, imm_l};
    end else begin : g_trunc_l
      assign sx_long = imm_l[DATA_W-1:0];
      assign zx_long = imm_l[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    src_a  = '0;
    src_b  = '0;
    do_sub = 1'b0;
    unique case (op)
      OP_ADD_RR: begin src_a = rs2; src_b = rs1;      end
      OP_ADD_IS: begin src_a = rs2; src_b = sx_short; end
      OP_ADD_IL: begin src_a = rs1; src_b = sx_long;  end
      OP_AND_RR: begin src_a = rs2; src_b = rs1;      end
      OP_AND_IL: begin src_a = rs1; src_b = zx_long;  end
      OP_CMP_RR: begin src_a = rs2; src_b = rs1;      do_sub = 1'b1; end
      OP_CMP_IS: begin src_a = rs2; src_b = sx_short; do_sub = 1'b1; end
      default:   begin src_a = '0;  src_b = '0;       end
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
  assign sum   = wide[DATA_W-1:0];
  // borrow is the inverse of carry-out for a - b computed as a + ~b + 1
  assign carry = sub ? ~wide[DATA_W] : wide[DATA_W];
  assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/alu_flag_policy.sv
module alu_flag_policy
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   arith_res,
  input  logic                arith_cy,
  input  logic                arith_ov,
  input  logic [DATA_W-1:0]   logic_res,
  output logic [DATA_W-1:0]   res,
  output logic                we,
  output logic [FLAG_W-1:0]   fval,
  output logic [FLAG_W-1:0]   fmask
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    res   = '0;
    we    = 1'b0;
    fval  = '0;
    fmask = '0;
    unique case (op)
      OP_ADD_RR, OP_ADD_IS, OP_ADD_IL, OP_CMP_RR, OP_CMP_IS: begin
        res              = arith_res;
        we               = !(op == OP_CMP_RR || op == OP_CMP_IS);
        fmask[FCY_BIT]   = 1'b1;
        fmask[FOV_BIT]   = 1'b1;
        fmask[FS_BIT]    = 1'b1;
        fmask[FZ_BIT]    = 1'b1;
        fval[FCY_BIT]    = arith_cy;
        fval[FOV_BIT]    = arith_ov;
        fval[FS_BIT]     = arith_res[MSB];
        fval[FZ_BIT]     = (arith_res == '0);
      end
      OP_AND_RR: begin
        res              = logic_res;
        we               = 1'b1;
        fmask[FOV_BIT]   = 1'b1;
        fmask[FS_BIT]    = 1'b1;
        fmask[FZ_BIT]    = 1'b1;
        fval[FS_BIT]     = logic_res[MSB];
        fval[FZ_BIT]     = (logic_res == '0);
      end
      OP_AND_IL: begin
        res              = logic_res;
        we               = 1'b1;
        fmask[FOV_BIT]   = 1'b1;
        fmask[FS_BIT]    = 1'b1;
        fmask[FZ_BIT]    = 1'b1;
        fval[FZ_BIT]     = (logic_res == '0);
      end
      default: begin
        res = '0;
      end
    endcase
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_S_W = 5,
  parameter int IMM_L_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          op,
  input  logic [DATA_W-1:0]   rs1,
  input  logic [DATA_W-1:0]   rs2,
  input  logic [IMM_S_W-1:0]  imm_s,
  input  logic [IMM_L_W-1:0]  imm_l,
  output logic [DATA_W-1:0]   result,
  output logic                wr_en,
  output logic [FLAG_W-1:0]   flag_val,
  output logic [FLAG_W-1:0]   flag_mask
);

  localparam int MSB = DATA_W - 1;

  alu_op_e            op_e;
  logic [DATA_W-1:0]  src_a, src_b;
  logic               do_sub;
  logic [DATA_W-1:0]  arith_res, logic_res;
  logic               arith_cy, arith_ov;
  logic [DATA_W-1:0]  res_d;
  logic               we_d;
  logic [FLAG_W-1:0]  fval_d, fmask_d;

  assign op_e = alu_op_e'(op);

  alu_operand_mux #(
    .DATA_W (DATA_W),
    .IMM_S_W(IMM_S_W),
    .IMM_L_W(IMM_L_W)
  ) u_mux (
    .op    (op_e),
    .rs1   (rs1),
    .rs2   (rs2),
    .imm_s (imm_s),
    .imm_l (imm_l),
    .src_a (src_a),
    .src_b (src_b),
    .do_sub(do_sub)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a    (src_a),
    .b    (src_b),
    .sub  (do_sub),
    .sum  (arith_res),
    .carry(arith_cy),
    .ovf  (arith_ov)
  );

  assign logic_res = src_a & src_b;

  alu_flag_policy #(.DATA_W(DATA_W)) u_policy (
    .op       (op_e),
    .arith_res(arith_res),
    .arith_cy (arith_cy),
    .arith_ov (arith_ov),
    .logic_res(logic_res),
    .res      (res_d),
    .we       (we_d),
    .fval     (fval_d),
    .fmask    (fmask_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_en     <= 1'b0;
      flag_val  <= '0;
      flag_mask <= '0;
    end else begin
      result    <= res_d;
      wr_en     <= we_d;
      flag_val  <= fval_d;
      flag_mask <= fmask_d;
    end
  end

  // R9
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(op) == 3'd5 || $past(op) == 3'd6) |-> !wr_en);

  // R3
  arith_mask_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(op) <= 3'd2 || $past(op) == 3'd5 || $past(op) == 3'd6) |-> (flag_mask[3:0] == 4'hF));

  // R7
  and_carry_keep_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(op) == 3'd3 || $past(op) == 3'd4) |-> (!flag_mask[FCY_BIT] && !flag_val[FOV_BIT]));

  // R8
  andi_sign_clear_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(op) == 3'd4) |-> (flag_mask[FS_BIT] && !flag_val[FS_BIT]));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_mask[FZ_BIT] |-> (flag_val[FZ_BIT] == (result == '0)));

  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_val[FS_BIT] |-> result[MSB]);

  // R10
  unmasked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((flag_val & ~flag_mask) == '0));

  // R11
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(op) == 3'd7) |-> (!wr_en && flag_mask == '0 && result == '0));

endmodule

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/1ps
module sim_alu_flag_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic [31:0] rs1, rs2;
  logic [4:0]  imm_s;
  logic [15:0] imm_l;
  logic [31:0] result;
  logic        wr_en;
  logic [4:0]  flag_val, flag_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_flag_unit u0 (
    .clk(clk), .rst(rst), .op(op), .rs1(rs1), .rs2(rs2),
    .imm_s(imm_s), .imm_l(imm_l), .result(result), .wr_en(wr_en),
    .flag_val(flag_val), .flag_mask(flag_mask)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model built from the requirement text
  task automatic model(input logic [2:0] o, input logic [31:0] a1, input logic [31:0] a2,
                       input logic [4:0] is, input logic [15:0] il,
                       output logic [31:0] r, output logic we,
                       output logic [4:0] fv, output logic [4:0] fm);
    logic [31:0] sxs, sxl, zxl, x, y;
    logic [32:0] w;
    logic        cy, ov;
    sxs = {{27{is[4]}}, is};
    sxl = {{16{il[15]}}, il};
    zxl = {16'h0, il};
    r = 0; we = 0; fv = 0; fm = 0; x = 0; y = 0;
    case (o)
      3'd0, 3'd1, 3'd2: begin
        x = (o == 3'd2) ? a1 : a2;
        y = (o == 3'd0) ? a1 : (o == 3'd1) ? sxs : sxl;
        w = {1'b0, x} + {1'b0, y};
        r = w[31:0]; cy = w[32];
        ov = (x[31] == y[31]) && (r[31] != x[31]);
        we = 1; fm = 5'b01111; fv = {1'b0, cy, ov, r[31], r == 0};
      end
      3'd5, 3'd6: begin
        x = a2; y = (o == 3'd5) ? a1 : sxs;
        r = x - y; cy = (x < y);
        ov = (x[31] != y[31]) && (r[31] != x[31]);
        we = 0; fm = 5'b01111; fv = {1'b0, cy, ov, r[31], r == 0};
      end
      3'd3: begin
        r = a2 & a1; we = 1; fm = 5'b00111; fv = {3'b000, r[31], r == 0};
      end
      3'd4: begin
        r = a1 & zxl; we = 1; fm = 5'b00111; fv = {4'b0000, r == 0};
      end
      default: ;
    endcase
  endtask

  task automatic apply(string req, input logic [2:0] o, input logic [31:0] a1,
                       input logic [31:0] a2, input logic [4:0] is, input logic [15:0] il);
    logic [31:0] er; logic ew; logic [4:0] efv, efm;
    @(negedge clk);
    op = o; rs1 = a1; rs2 = a2; imm_s = is; imm_l = il;
    model(o, a1, a2, is, il, er, ew, efv, efm);
    @(posedge clk); #1;
    check(req, "result", result, er);
    check(req, "wr_en", {31'h0, wr_en}, {31'h0, ew});
    check(req, "flag_val", {27'h0, flag_val}, {27'h0, efv});
    check(req, "flag_mask", {27'h0, flag_mask}, {27'h0, efm});
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1; op = 3'd0; rs1 = 32'hFFFF_FFFF; rs2 = 32'h1; imm_s = 0; imm_l = 0;
    @(posedge clk); #1;
    check("R1", "result", result, 0);
    check("R1", "wr_en", {31'h0, wr_en}, 0);
    check("R1", "flags", {22'h0, flag_val, flag_mask}, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_add;
    apply("R2", 3'd0, 32'h0000_0005, 32'h0000_0007, 5'd0, 16'd0);
    apply("R4", 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 16'd0);
    apply("R5", 3'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, 16'd0);
    apply("R5", 3'd0, 32'h0000_0001, 32'h7FFF_FFFF, 5'd0, 16'd0);
    apply("R2", 3'd1, 32'h0, 32'h0000_0010, 5'h1F, 16'd0);
    apply("R4", 3'd1, 32'h0, 32'h0000_0002, 5'h1E, 16'd0);
    apply("R2", 3'd2, 32'h0001_0000, 32'hDEAD_BEEF, 5'd0, 16'h8000);
    apply("R3", 3'd2, 32'h7FFF_8000, 32'h0, 5'd0, 16'h7FFF);
  endtask

  task automatic t_and;
    apply("R7", 3'd3, 32'hF0F0_F0F0, 32'h8F0F_FFFF, 5'd0, 16'd0);
    apply("R7", 3'd3, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 5'd0, 16'd0);
    apply("R8", 3'd4, 32'hFFFF_FFFF, 32'h0, 5'd0, 16'hFFFF);
    apply("R8", 3'd4, 32'h8000_0000, 32'h0, 5'd0, 16'h8000);
  endtask

  task automatic t_cmp;
    apply("R9", 3'd5, 32'h1234_5678, 32'h1234_5678, 5'd0, 16'd0);
    apply("R4", 3'd5, 32'h0000_0002, 32'h0000_0001, 5'd0, 16'd0);
    apply("R5", 3'd5, 32'h0000_0001, 32'h8000_0000, 5'd0, 16'd0);
    apply("R6", 3'd6, 32'h0, 32'hFFFF_FFFF, 5'h1F, 16'd0);
    apply("R9", 3'd6, 32'h0, 32'h0000_0003, 5'h05, 16'd0);
  endtask

  task automatic t_misc;
    apply("R11", 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'h1F, 16'hFFFF);
    apply("R10", 3'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, 16'd0);
    apply("R10", 3'd3, 32'h8000_0000, 32'h8000_0000, 5'd0, 16'd0);
    apply("R1", 3'd5, 32'h5, 32'h5, 5'd0, 16'd0);
    apply("R1", 3'd2, 32'h1, 32'h0, 5'd0, 16'hFFFF);
  endtask

  initial begin
    rst = 1; op = 0; rs1 = 0; rs2 = 0; imm_s = 0; imm_l = 0;
    repeat (3) @(posedge clk);
    t_reset;
    t_add;
    t_and;
    t_cmp;
    t_misc;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule